// File: doc/BRIEF.md
# Parallel I/O Host Bus Interface

This block is the processor-facing side of a parallel I/O peripheral with several ports (two by default). It samples the active-low chip enable, I/O request, read and first-machine-cycle strobes on the system clock, together with a port select and a control/data select. From these it decides what kind of bus cycle is running. Register writes store port output data, command bytes or interrupt vectors. Register reads return a port's output data. Interrupt acknowledge cycles return the vector of the highest-priority pending port. A bare first-machine-cycle strobe acts as a soft reset.

The bidirectional data bus is split into `d_in`, `d_out` and `d_oe`, and the pad logic combines them into a tristate bus. All strobes and `d_in` pass through one sampling register. A write is applied on the first sampled cycle of its strobe, and a read drives the bus from the first cycle after the strobe is sampled.

Top module: `pio_host_if`

## Requirements
- R1: After `rst_n` is released, `d_oe` is 0, `irq_n` is 1 and every port output and command register reads 0.
- R2: A write cycle (`ce_n`=0, `iorq_n`=0, `rd_n`=1, `m1_n`=1) with `cmd_sel`=0 stores `d_in` in the output register of the port that `port_sel` selects (0 = port A, 1 = port B). Other ports are unchanged.
- R3: A write cycle with `cmd_sel`=1 stores `d_in` in the selected port's command register when `d_in[0]`=1. When `d_in[0]`=0 it stores `d_in` as that port's interrupt vector, and the command register is left unchanged.
- R4: A read cycle (`ce_n`=0, `iorq_n`=0, `rd_n`=0, `m1_n`=1) raises `d_oe` and drives the selected port's output register on `d_out`. With no read or acknowledge in progress, `d_oe` is 0.
- R5: While `ce_n`=1, neither writes nor reads take effect: no register changes and `d_oe` stays 0.
- R6: An instruction fetch (`m1_n`=0, `rd_n`=0, `iorq_n`=1) neither changes a register nor drives the bus.
- R7: A write strobe held for several cycles updates the register once, with the byte sampled in its first cycle. Later changes of `d_in` during the same strobe are ignored.
- R8: An interrupt acknowledge (`m1_n`=0, `iorq_n`=0) raises `d_oe` and drives the vector of the lowest-numbered pending port on `d_out`, so port A wins over port B. That port's pending request is cleared. `irq_n` is 0 while any request is pending.
- R9: An interrupt acknowledge while no request is pending leaves `d_oe` at 0.
- R10: `m1_n`=0 with `rd_n`=1 and `iorq_n`=1 clears the output registers, the command registers and the pending requests. The interrupt vectors are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | First-machine-cycle strobe, active low |
| port_sel | input | SEL_W | Port select (0 = port A, 1 = port B) |
| cmd_sel | input | 1 | 1 = command write, 0 = data transfer |
| d_in | input | DATA_W | Data bus input from the processor |
| int_req | input | NUM_PORTS | Per-port interrupt request pulses from the port logic |
| d_out | output | DATA_W | Data bus output toward the processor |
| d_oe | output | 1 | Data bus drive enable; the bus floats when 0 |
| irq_n | output | 1 | Interrupt request, active low |
| port_dout | output | NUM_PORTS*DATA_W | Output data registers, port 0 in the low byte |
| port_cmd | output | NUM_PORTS*DATA_W | Command registers, port 0 in the low byte |

## Verification
The bench builds the block with its defaults: two ports, an 8-bit bus and a one-bit port select. With these values every select code maps to a real port. Both ports can request in the same cycle, which makes the A-over-B arbitration and the second acknowledge that serves port B reachable. Bit 0 of the 8-bit command byte covers both the vector path and the command path.

// File: rtl/pio_pkg.sv
package pio_pkg;

   // Decoded, sampled bus cycle qualifiers
   typedef struct packed {
      logic rd_v;       // valid register read in progress
      logic wr_pulse;   // first sampled cycle of a register write
      logic ack_start;  // first sampled cycle of an interrupt acknowledge
      logic ack_held;   // acknowledge in its second or later sampled cycle
      logic srst;       // soft reset condition
   } bus_dec_t;

endpackage

// File: rtl/pio_strobe_dec.sv
module pio_strobe_dec
   import pio_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              m1_n,
   input  logic [SEL_W-1:0]  port_sel,
   input  logic              cmd_sel,
   input  logic [DATA_W-1:0] d_in,
   output bus_dec_t          dec,
   output logic [SEL_W-1:0]  s_sel,
   output logic              s_cmd,
   output logic [DATA_W-1:0] s_data
);

   logic s_ce, s_iorq, s_rd, s_m1;
   logic wr_lvl, ack_lvl;
   logic wr_prev, ack_prev;

   // one sampling stage for every strobe and the bus byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_ce   <= 1'b0;
         s_iorq <= 1'b0;
         s_rd   <= 1'b0;
         s_m1   <= 1'b0;
         s_sel  <= '0;
         s_cmd  <= 1'b0;
         s_data <= '0;
      end else begin
         s_ce   <= ~ce_n;
         s_iorq <= ~iorq_n;
         s_rd   <= ~rd_n;
         s_m1   <= ~m1_n;
         s_sel  <= port_sel;
         s_cmd  <= cmd_sel;
         s_data <= d_in;
      end
   end

   assign wr_lvl  = s_ce & s_iorq & ~s_rd & ~s_m1;
   assign ack_lvl = s_m1 & s_iorq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev  <= 1'b0;
         ack_prev <= 1'b0;
      end else begin
         wr_prev  <= wr_lvl;
         ack_prev <= ack_lvl;
      end
   end

   always_comb begin
      dec           = '0;
      dec.rd_v      = s_ce & s_iorq & s_rd & ~s_m1;
      dec.wr_pulse  = wr_lvl & ~wr_prev;
      dec.ack_start = ack_lvl & ~ack_prev;
      dec.ack_held  = ack_lvl & ack_prev;
      dec.srst      = s_m1 & ~s_rd & ~s_iorq;
   end

endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              wr_data,
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] cmd,
   output logic [DATA_W-1:0] vec
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         cmd  <= '0;
      end else if (srst) begin
         dout <= '0;
         cmd  <= '0;
      end else if (wr_data) begin
         dout <= din;
      end else if (wr_cmd && din[0]) begin
         cmd <= din;
      end
   end

   // vector survives the soft reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec <= '0;
      end else if (wr_cmd && !din[0]) begin
         vec <= din;
      end
   end

endmodule

// File: rtl/pio_irq_arb.sv
module pio_irq_arb #(
   parameter int NUM_PORTS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 srst,
   input  logic [NUM_PORTS-1:0] int_req,
   input  logic                 ack_start,
   output logic [NUM_PORTS-1:0] ack_owner,
   output logic                 irq_n
);

   logic [NUM_PORTS-1:0] pend;
   logic [NUM_PORTS-1:0] grant;
   logic [NUM_PORTS-1:0] clr;

   // lowest index wins
   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (pend[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assign clr = ack_start ? grant : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= '0;
         ack_owner <= '0;
      end else if (srst) begin
         pend      <= '0;
         ack_owner <= '0;
      end else begin
         pend <= (pend & ~clr) | int_req;
         if (ack_start) ack_owner <= grant;
      end
   end

   assign irq_n = ~|pend;

endmodule

// File: rtl/pio_host_if.sv
module pio_host_if
   import pio_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int DATA_W    = 8,
   localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int FLAT_W   = NUM_PORTS * DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce_n,
   input  logic                 iorq_n,
   input  logic                 rd_n,
   input  logic                 m1_n,
   input  logic [SEL_W-1:0]     port_sel,
   input  logic                 cmd_sel,
   input  logic [DATA_W-1:0]    d_in,
   input  logic [NUM_PORTS-1:0] int_req,
   output logic [DATA_W-1:0]    d_out,
   output logic                 d_oe,
   output logic                 irq_n,
   output logic [FLAT_W-1:0]    port_dout,
   output logic [FLAT_W-1:0]    port_cmd
);

   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("pio_host_if: NUM_PORTS must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("pio_host_if: DATA_W must be at least 2");
   end

   bus_dec_t              dec;
   logic [SEL_W-1:0]      s_sel;
   logic                  s_cmd;
   logic [DATA_W-1:0]     s_data;
   logic [NUM_PORTS-1:0]  ack_owner;
   logic [FLAT_W-1:0]     vec_flat;
   logic [DATA_W-1:0]     rd_mux;
   logic [DATA_W-1:0]     vec_mux;
   logic                  ack_drive;

   pio_strobe_dec #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .iorq_n   (iorq_n),
      .rd_n     (rd_n),
      .m1_n     (m1_n),
      .port_sel (port_sel),
      .cmd_sel  (cmd_sel),
      .d_in     (d_in),
      .dec      (dec),
      .s_sel    (s_sel),
      .s_cmd    (s_cmd),
      .s_data   (s_data)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = (s_sel == SEL_W'(p));
      pio_port_regs #(.DATA_W(DATA_W)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .srst    (dec.srst),
         .wr_data (dec.wr_pulse & ~s_cmd & hit),
         .wr_cmd  (dec.wr_pulse &  s_cmd & hit),
         .din     (s_data),
         .dout    (port_dout[p*DATA_W +: DATA_W]),
         .cmd     (port_cmd[p*DATA_W +: DATA_W]),
         .vec     (vec_flat[p*DATA_W +: DATA_W])
      );
   end

   pio_irq_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (dec.srst),
      .int_req   (int_req),
      .ack_start (dec.ack_start),
      .ack_owner (ack_owner),
      .irq_n     (irq_n)
   );

   always_comb begin
      rd_mux  = '0;
      vec_mux = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (s_sel == SEL_W'(p)) rd_mux = port_dout[p*DATA_W +: DATA_W];
         if (ack_owner[p]) vec_mux = vec_mux | vec_flat[p*DATA_W +: DATA_W];
      end
   end

   assign ack_drive = dec.ack_held & (|ack_owner);
   assign d_oe      = dec.rd_v | ack_drive;
   assign d_out     = ack_drive ? vec_mux : (dec.rd_v ? rd_mux : '0);

endmodule

// File: rtl/pio_host_if_chk.sv
module pio_host_if_chk #(
   parameter int NUM_PORTS = 2,
   parameter int DATA_W    = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ce_n,
   input logic                          iorq_n,
   input logic                          rd_n,
   input logic                          m1_n,
   input logic                          d_oe,
   input logic [NUM_PORTS*DATA_W-1:0]   port_dout,
   input logic [NUM_PORTS-1:0]          ack_owner
);

   AST_OE_NEEDS_IORQ: assert property (@(posedge clk) disable iff (!rst_n)
      d_oe |-> !$past(iorq_n)); // R4

   AST_READ_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (d_oe && $past(m1_n)) |-> !$past(ce_n)); // R5

   AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(m1_n) && !$past(rd_n) && $past(iorq_n)) |-> !d_oe); // R6

   AST_DOUT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_dout) |-> (!$past(iorq_n, 2) || !$past(m1_n, 2))); // R2

   AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_owner)); // R8

endmodule

bind pio_host_if pio_host_if_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .iorq_n    (iorq_n),
   .rd_n      (rd_n),
   .m1_n      (m1_n),
   .d_oe      (d_oe),
   .port_dout (port_dout),
   .ack_owner (ack_owner)
);

// File: tb/tb_pio_host_if.sv
module tb_pio_host_if;

   localparam int NP = 2;
   localparam int DW = 8;
   localparam int NV = 10;

   // entry: [18:17] op (0 data write, 1 command write, 2 read), [16] port, [15:8] byte, [7:0] expected
   localparam logic [18:0] TBL [NV] = '{
      {2'd0, 1'b0, 8'h5A, 8'h5A},
      {2'd0, 1'b1, 8'hC3, 8'hC3},
      {2'd1, 1'b0, 8'h0F, 8'h0F},
      {2'd1, 1'b1, 8'h31, 8'h31},
      {2'd1, 1'b0, 8'hE0, 8'h0F},
      {2'd1, 1'b1, 8'h42, 8'h31},
      {2'd2, 1'b0, 8'h00, 8'h5A},
      {2'd2, 1'b1, 8'h00, 8'hC3},
      {2'd0, 1'b0, 8'h81, 8'h81},
      {2'd2, 1'b0, 8'h00, 8'h81}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
   logic port_sel = 1'b0, cmd_sel = 1'b0;
   logic [DW-1:0] d_in = '0;
   logic [NP-1:0] int_req = '0;
   logic [DW-1:0] d_out;
   logic d_oe, irq_n;
   logic [NP*DW-1:0] port_dout, port_cmd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pio_host_if #(.NUM_PORTS(NP), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n),
      .m1_n(m1_n), .port_sel(port_sel), .cmd_sel(cmd_sel), .d_in(d_in),
      .int_req(int_req), .d_out(d_out), .d_oe(d_oe), .irq_n(irq_n),
      .port_dout(port_dout), .port_cmd(port_cmd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic ce, input logic io, input logic rd, input logic m1,
                        input logic sel, input logic cs, input logic [DW-1:0] d);
      @(negedge clk);
      ce_n = ce; iorq_n = io; rd_n = rd; m1_n = m1;
      port_sel = sel; cmd_sel = cs; d_in = d;
   endtask

   // apply a cycle and stop at the negedge after two rising edges
   task automatic cyc(input logic ce, input logic io, input logic rd, input logic m1,
                      input logic sel, input logic cs, input logic [DW-1:0] d);
      drive(ce, io, rd, m1, sel, cs, d);
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_req(input logic [NP-1:0] r);
      @(negedge clk);
      int_req = r;
      @(negedge clk);
      int_req = '0;
   endtask

   function automatic logic [DW-1:0] dq(input int p);
      return port_dout[p*DW +: DW];
   endfunction

   function automatic logic [DW-1:0] cq(input int p);
      return port_cmd[p*DW +: DW];
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 d_oe", d_oe, 0);
      chk("R1 irq_n", irq_n, 1);
      chk("R1 port_dout", port_dout, 0);
      chk("R1 port_cmd", port_cmd, 0);

      // table walk: R2 data, R3 command/vector, R4 read
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         logic sel;
         logic [DW-1:0] b, e;
         {op, sel, b, e} = TBL[i];
         case (op)
            2'd0: begin
               cyc(1'b0, 1'b0, 1'b1, 1'b1, sel, 1'b0, b);
               chk("R2 data write", dq(int'(sel)), e);
            end
            2'd1: begin
               cyc(1'b0, 1'b0, 1'b1, 1'b1, sel, 1'b1, b);
               chk("R3 command write", cq(int'(sel)), e);
            end
            default: begin
               cyc(1'b0, 1'b0, 1'b0, 1'b1, sel, 1'b0, '0);
               chk("R4 read oe", d_oe, 1);
               chk("R4 read data", d_out, e);
            end
         endcase
         idle();
         chk("R4 idle oe", d_oe, 0);
      end
      chk("R2 other port kept", dq(1), 8'hC3);

      // R7: byte changes mid-strobe, only first is stored
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11);
      @(posedge clk);
      @(negedge clk);
      d_in = 8'h22;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 single update", dq(0), 8'h11);
      idle();
      chk("R7 after release", dq(0), 8'h11);

      // R5: chip enable high
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h77);
      chk("R5 no drive on write", d_oe, 0);
      idle();
      chk("R5 write ignored", dq(1), 8'hC3);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R5 read ignored", d_oe, 0);
      idle();

      // R6: instruction fetch
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h99);
      chk("R6 fetch no drive", d_oe, 0);
      idle();
      chk("R6 fetch no change", dq(0), 8'h11);

      // R9: acknowledge with nothing pending
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      chk("R9 no vector", d_oe, 0);
      idle();

      // R8: both request, A first
      pulse_req(2'b11);
      chk("R8 irq asserted", irq_n, 0);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      chk("R8 ack oe A", d_oe, 1);
      chk("R8 vector A", d_out, 8'hE0);
      idle();
      chk("R8 B still pending", irq_n, 0);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      chk("R8 vector B", d_out, 8'h42);
      idle();
      chk("R8 all served", irq_n, 1);
      pulse_req(2'b10);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      chk("R8 lone B vector", d_out, 8'h42);
      idle();

      // R10: soft reset
      pulse_req(2'b01);
      chk("R10 pending before", irq_n, 0);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      idle();
      chk("R10 dout cleared", port_dout, 0);
      chk("R10 cmd cleared", port_cmd, 0);
      chk("R10 pending cleared", irq_n, 1);
      pulse_req(2'b01);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      chk("R10 vector kept", d_out, 8'hE0);
      idle();

      done = 1'b1;
      summary();
      $finish;
   end

endmodule